// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single down-counting timer. Software programs it through an APB slave port and it signals expiry on one interrupt line. Software writes a start value, chooses one of two modes and then sets the run bit. The counter steps down by one on every cycle in which the timer-tick enable input is high. When it passes through zero it raises its interrupt and reloads itself.

In periodic mode the reload uses the programmed start value, so the timer produces a steady interval. In free-running mode the reload value is all ones. Software can then read the live count and take its bitwise inverse as an elapsed-time value.

The interrupt can be masked without losing the underlying event. It is acknowledged by reading an acknowledge register, not by writing one. A few system-level registers give the combined status, a second acknowledge location, the raw (unmasked) status and a fixed version word.

Top module: `apb_countdown_timer`

## Requirements
- R1: After reset every register reads zero, except the version word at offset 0xAC, which reads the parameter VERSION (default 0x54494D31). The irq output is low.
- R2: While control bit 0 (run) is 0, the count held at offset 0x04 does not change, whatever tickEn does.
- R3: A write to control (offset 0x08) that sets bit 0 while run was 0 arms a start. The next cycle with tickEn high loads the count from the start-value register (offset 0x00).
- R4: While running, the count drops by exactly one on each clock edge at which tickEn is high, and holds when tickEn is low.
- R5: In periodic mode (control bit 1 = 1), a tick that finds the count at zero reloads the start value and sets the pending interrupt on the same edge.
- R6: In free-running mode (control bit 1 = 0), a tick that finds the count at zero reloads 0xFFFFFFFF and sets the pending interrupt.
- R7: When control bit 2 (mask) is 1, irq stays low and bit 0 of offsets 0x10 and 0xA0 reads 0. Bit 0 of the raw status at offset 0xA8 still sets on expiry.
- R8: A read of offset 0x0C returns zero and clears the pending interrupt.
- R9: A read of offset 0xA4 returns zero and also clears the pending interrupt.
- R10: If an expiry and an acknowledge read fall on the same edge, the interrupt stays pending.
- R11: Writes to any offset other than 0x00 and 0x08 have no effect. Control reads back its three bits in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Timer tick qualifier, one count step per high cycle |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte offset |
| pwdata | input | WIDTH | APB write data |
| prdata | output | WIDTH | APB read data, combinational |
| irq | output | 1 | Masked interrupt, active high |

## Verification
Two events can land on the same edge: the counter expiring, which sets the pending flag, and a read of an acknowledge register, which clears it. The bench brings the count to zero with ticks held off. It then raises tickEn only during the access phase of a read of 0x0C, so the expiry and the acknowledge share one edge. It judges the result by irq staying high, and by the count showing the free-running reload value after that edge. A plain acknowledge read that follows must then bring irq low.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // Offsets that software decodes
  localparam logic [7:0] OFF_LOAD    = 8'h00;
  localparam logic [7:0] OFF_COUNT   = 8'h04;
  localparam logic [7:0] OFF_CTRL    = 8'h08;
  localparam logic [7:0] OFF_ACK     = 8'h0C;
  localparam logic [7:0] OFF_STAT    = 8'h10;
  localparam logic [7:0] OFF_SYSSTAT = 8'hA0;
  localparam logic [7:0] OFF_SYSACK  = 8'hA4;
  localparam logic [7:0] OFF_RAW     = 8'hA8;
  localparam logic [7:0] OFF_VER     = 8'hAC;

  // Strobes and mode bits from the register side to the counter side
  typedef struct packed {
    logic run;
    logic periodic;
    logic startReq;
    logic irqClear;
  } tmrStrobe_t;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int          WIDTH   = 32,
  parameter int          ADDR_W  = 8,
  parameter logic [WIDTH-1:0] VERSION = 32'h5449_4D31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WIDTH-1:0]  pwdata,
  input  logic [WIDTH-1:0]  cnt,
  input  logic              rawIrq,
  output logic [WIDTH-1:0]  prdata,
  output logic              irq,
  output logic              maskOut,
  output logic [WIDTH-1:0]  loadVal,
  output tmrStrobe_t        strb
);
  localparam int CTRL_BITS = 3;

  logic access, wrEn, rdEn;
  logic hitLoad, hitCtrl, hitAck, hitSysAck;
  logic [WIDTH-1:0] loadQ;
  logic runQ, modeQ, maskQ;
  logic maskedStat;

  assign access    = psel & penable;
  assign wrEn      = access & pwrite;
  assign rdEn      = access & ~pwrite;
  assign hitLoad   = (paddr == ADDR_W'(OFF_LOAD));
  assign hitCtrl   = (paddr == ADDR_W'(OFF_CTRL));
  assign hitAck    = (paddr == ADDR_W'(OFF_ACK));
  assign hitSysAck = (paddr == ADDR_W'(OFF_SYSACK));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ <= '0;
      runQ  <= 1'b0;
      modeQ <= 1'b0;
      maskQ <= 1'b0;
    end else if (wrEn) begin
      if (hitLoad) loadQ <= pwdata;
      if (hitCtrl) begin
        runQ  <= pwdata[0];
        modeQ <= pwdata[1];
        maskQ <= pwdata[2];
      end
    end
  end

  assign maskedStat    = rawIrq & ~maskQ;
  assign irq           = maskedStat;
  assign maskOut       = maskQ;
  assign loadVal       = loadQ;
  assign strb.run      = runQ;
  assign strb.periodic = modeQ;
  assign strb.startReq = wrEn & hitCtrl & pwdata[0] & ~runQ;
  assign strb.irqClear = rdEn & (hitAck | hitSysAck);

  always_comb begin
    prdata = '0;
    case (paddr)
      ADDR_W'(OFF_LOAD):    prdata = loadQ;
      ADDR_W'(OFF_COUNT):   prdata = cnt;
      ADDR_W'(OFF_CTRL):    prdata = WIDTH'({maskQ, modeQ, runQ});
      ADDR_W'(OFF_STAT),
      ADDR_W'(OFF_SYSSTAT): prdata = WIDTH'(maskedStat);
      ADDR_W'(OFF_RAW):     prdata = WIDTH'(rawIrq);
      ADDR_W'(OFF_VER):     prdata = VERSION;
      default:              prdata = '0;
    endcase
  end

  if (CTRL_BITS > WIDTH) begin : g_badWidth
    initial $error("WIDTH too small for control bits");
  end
endmodule

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  tmrStrobe_t       strb,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] cnt,
  output logic             rawIrq,
  output logic             armed
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] cntQ;
  logic armedQ, rawQ;
  logic step, expire;

  assign step   = strb.run & tickEn;
  assign expire = step & ~armedQ & (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      armedQ <= 1'b0;
      rawQ   <= 1'b0;
    end else begin
      if (strb.startReq)   armedQ <= 1'b1;
      else if (step)       armedQ <= 1'b0;

      if (step) begin
        if (armedQ)              cntQ <= loadVal;
        else if (cntQ == '0)     cntQ <= strb.periodic ? loadVal : ALL_ONES;
        else                     cntQ <= cntQ - 1'b1;
      end

      if (expire)             rawQ <= 1'b1;
      else if (strb.irqClear) rawQ <= 1'b0;
    end
  end

  assign cnt    = cntQ;
  assign rawIrq = rawQ;
  assign armed  = armedQ;
endmodule

// File: rtl/apb_countdown_timer.sv
module apb_countdown_timer
  import cdt_pkg::*;
#(
  parameter int               WIDTH   = 32,
  parameter int               ADDR_W  = 8,
  parameter logic [WIDTH-1:0] VERSION = 32'h5449_4D31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WIDTH-1:0]  pwdata,
  output logic [WIDTH-1:0]  prdata,
  output logic              irq
);
  tmrStrobe_t       strb;
  logic [WIDTH-1:0] loadVal, cnt;
  logic             rawIrq, armed, maskOut;

  cdt_ctrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cnt(cnt), .rawIrq(rawIrq),
    .prdata(prdata), .irq(irq), .maskOut(maskOut), .loadVal(loadVal), .strb(strb)
  );

  cdt_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .loadVal(loadVal),
    .cnt(cnt), .rawIrq(rawIrq), .armed(armed)
  );
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              irq,
  input logic              run,
  input logic              periodic,
  input logic              mask,
  input logic              armed,
  input logic              rawIrq,
  input logic [WIDTH-1:0]  cnt,
  input logic [WIDTH-1:0]  loadVal
);
  logic atZeroTick, ackRead;
  assign atZeroTick = run && tickEn && !armed && (cnt == '0);
  assign ackRead    = psel && penable && !pwrite && (paddr == ADDR_W'(8'h0C));

  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == $past(cnt)));

  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> (cnt == $past(cnt)));

  a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rstN)
    (atZeroTick && periodic) |=> (cnt == $past(loadVal)) && rawIrq);

  a_r6_freerun_reload: assert property (@(posedge clk) disable iff (!rstN)
    (atZeroTick && !periodic) |=> (cnt == '1) && rawIrq);

  a_r7_mask_quiet: assert property (@(posedge clk) disable iff (!rstN)
    mask |-> !irq);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && !atZeroTick) |=> !rawIrq);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && atZeroTick) |=> rawIrq);
endmodule

bind apb_countdown_timer cdt_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .irq(irq), .run(strb.run),
  .periodic(strb.periodic), .mask(maskOut), .armed(armed), .rawIrq(rawIrq),
  .cnt(cnt), .loadVal(loadVal)
);

// File: tb/apb_countdown_timer_tb.sv
module apb_countdown_timer_tb;
  localparam int W = 32;
  localparam logic [W-1:0] VER = 32'h5449_4D31;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [W-1:0] pwdata = '0;
  logic [W-1:0] prdata;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  apb_countdown_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  // Monitor: compares read data in the access phase, halfway before the edge
  initial forever begin
    @(negedge clk); #2;
    if (psel && penable && !pwrite && expQ.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (prdata !== e) begin
        failures++;
        $display("FAIL %s addr=%02h actual=%08h expected=%08h", t, paddr, prdata, e);
      end
    end
  end

  task automatic apbWrite(input logic [7:0] a, input logic [W-1:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [7:0] a, input logic [W-1:0] e,
                         input string t, input logic withTick);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; tickEn = withTick;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk); psel = 0; penable = 0; tickEn = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tickEn = 1; @(negedge clk); end
    tickEn = 0;
  endtask

  task automatic chkIrq(input logic e, input string t);
    #1; checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset values
    chkIrq(0, "R1");
    apbRead(8'h00, 0, "R1", 0);
    apbRead(8'h04, 0, "R1", 0);
    apbRead(8'h08, 0, "R1", 0);
    apbRead(8'h10, 0, "R1", 0);
    apbRead(8'hA0, 0, "R1", 0);
    apbRead(8'hA8, 0, "R1", 0);
    apbRead(8'hAC, VER, "R1", 0);

    // R3 start, R4 down count, R5 periodic reload
    apbWrite(8'h00, 5);
    apbWrite(8'h08, 3);
    apbRead(8'h04, 0, "R3 armed not loaded yet", 0);
    ticks(1);
    apbRead(8'h04, 5, "R3", 0);
    ticks(3);
    apbRead(8'h04, 2, "R4", 0);
    ticks(2);
    chkIrq(0, "R5 at zero before expiry");
    ticks(1);
    chkIrq(1, "R5");
    apbRead(8'h04, 5, "R5", 0);
    apbRead(8'h10, 1, "R7 status unmasked", 0);
    apbRead(8'hA0, 1, "R7 sys status unmasked", 0);

    // R8 acknowledge at 0x0C
    apbRead(8'h0C, 0, "R8", 0);
    chkIrq(0, "R8");
    apbRead(8'hA8, 0, "R8", 0);

    // R7 mask, R9 second acknowledge
    apbWrite(8'h08, 7);
    ticks(6);
    chkIrq(0, "R7");
    apbRead(8'h10, 0, "R7", 0);
    apbRead(8'hA0, 0, "R7", 0);
    apbRead(8'hA8, 1, "R7 raw", 0);
    apbRead(8'hA4, 0, "R9", 0);
    apbRead(8'hA8, 0, "R9", 0);

    // R2 stopped counter holds, R11 control readback
    apbWrite(8'h08, 2);
    ticks(3);
    apbRead(8'h04, 5, "R2", 0);
    apbRead(8'h08, 2, "R11", 0);

    // R6 free-running reload
    apbWrite(8'h00, 2);
    apbWrite(8'h08, 1);
    ticks(1);
    apbRead(8'h04, 2, "R6", 0);
    ticks(2);
    chkIrq(0, "R6 before expiry");
    ticks(1);
    chkIrq(1, "R6");
    apbRead(8'h04, 32'hFFFF_FFFF, "R6", 0);

    // R10 expiry and acknowledge on the same edge
    apbWrite(8'h08, 0);
    apbWrite(8'h00, 1);
    apbWrite(8'h08, 1);
    ticks(2);
    apbRead(8'h04, 0, "R10 count at zero", 0);
    chkIrq(1, "R10 still pending");
    apbRead(8'h0C, 0, "R10", 1);
    chkIrq(1, "R10");
    apbRead(8'h04, 32'hFFFF_FFFF, "R10", 0);
    apbRead(8'h0C, 0, "R8 plain ack", 0);
    chkIrq(0, "R8 plain ack");

    // R11 writes to read-only offsets ignored
    apbWrite(8'h04, 32'h55);
    apbWrite(8'hAC, 32'h1234);
    apbWrite(8'hA8, 32'h1);
    apbRead(8'h04, 32'hFFFF_FFFF, "R11", 0);
    apbRead(8'hAC, VER, "R11", 0);
    apbRead(8'hA8, 0, "R11", 0);
    apbRead(8'h00, 1, "R11", 0);

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule